// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Configuration Reader

This block is a master for a three-wire serial EEPROM organised as 64 words of 16 bits. When reset is released it issues a single read command on its own: a start bit, the read opcode and a six-bit address of zero. It then keeps the serial clock running. It collects the 16 bits of word 0, most significant bit first. Without sending another command, it goes on to collect the leading bits of word 1. The device's chip select is meant to be tied to the system reset, so the device is selected as soon as reset goes away.

Each collected bit is handed on as a one-cycle strobe with its data level, ready to shift into a configuration register. A one-cycle completion pulse follows the last bit. After that the serial clock stays low until the next reset. The parameter `WIDE` selects how many bits of word 1 are kept: two or three. The serial clock is derived from the system clock. Each of its high and low phases lasts `HALF_DIV` system clock cycles.

Top module: `mw_cfg_reader`

## Requirements
- R1: On the first nine rising edges of `sk_o` after reset release, `sdo_o` carries 1, 1, 0 and then six 0 bits. These are the start bit, read opcode `10` and address `000000`, in that order.
- R2: On rising edges 10 to 25, the block captures the 16 bits of word 0 from `sdi_i`, most significant bit first.
- R3: No new command is sent. Rising edges 26 onward capture the top bits of word 1: D15 and D14 when `WIDE`=0, and D15, D14 and D13 when `WIDE`=1. In total `sk_o` rises exactly 27 times (`WIDE`=0) or 28 times (`WIDE`=1).
- R4: Each captured bit appears on `cfg_bit_o` while `cfg_valid_o` is high for exactly one clock cycle. That cycle is the first one in which `sk_o` is seen high. The captured value is the `sdi_i` level just before that rising edge. `cfg_valid_o` is never high at any other time.
- R5: `sdo_o` changes only when `sk_o` falls or on reset. It is stable throughout every high phase of `sk_o`.
- R6: `sk_o` is low when reset is released. Once running, every high phase and every low phase of `sk_o` lasts exactly `HALF_DIV` clock cycles.
- R7: `done_o` is high for exactly one cycle: the first cycle in which `sk_o` is low after the final rising edge. After that, `sk_o` stays low and produces no further edges until reset.
- R8: While `rst_n` is low, `sk_o`, `cfg_valid_o` and `done_o` are low. Asserting reset in the middle of a read abandons it. The next release starts the whole command sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the EEPROM chip select |
| sk_o | output | 1 | Serial clock to the EEPROM |
| sdo_o | output | 1 | Command bits to the EEPROM data input |
| sdi_i | input | 1 | Data from the EEPROM data output |
| cfg_bit_o | output | 1 | Captured configuration bit |
| cfg_valid_o | output | 1 | One-cycle strobe for `cfg_bit_o` |
| done_o | output | 1 | One-cycle pulse after the last captured bit |

## Verification
The device words are loaded with several contrasting patterns:
- a mixed pattern;
- all ones;
- all zeros;
- alternating bits;
- values that differ only in the top bits of word 1.

These patterns expose errors in bit order, a stuck capture path, an off-by-one at the word boundary, and whether the wide variant keeps D13. The narrow and wide variants run side by side with different divider settings. This tells apart errors in transaction length and in phase timing. One read is cut short by reset to show that the command sequence restarts from the start bit.

// File: rtl/mw_cfg_pkg.sv
package mw_cfg_pkg;

  // Command: start bit, read opcode (2 bits), six-bit address of zero.
  localparam int unsigned CMD_LEN = 9;
  localparam logic [CMD_LEN-1:0] CMD_SEQ = 9'b1_10_000000;

  // Width of one EEPROM word.
  localparam int unsigned WORD_W = 16;

  typedef enum logic {
    SEQ_RUN  = 1'b0,
    SEQ_HALT = 1'b1
  } seq_st_e;

endpackage

// File: rtl/mw_sk_gen.sv
module mw_sk_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sk,
  output logic rise,
  output logic fall
);

  localparam int unsigned CNT_W = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sk_q, sk_d;
  logic             tick;

  always_comb begin
    tick  = run && (cnt_q == CNT_LAST);
    cnt_d = cnt_q;
    sk_d  = sk_q;
    if (!run) begin
      cnt_d = '0;
      sk_d  = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sk_d  = ~sk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sk_q  <= sk_d;
    end
  end

  assign sk   = sk_q;
  assign rise = tick && !sk_q;
  assign fall = tick && sk_q;

  // R6: once stopped, the serial clock rests low
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sk);

endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_cfg_pkg::*;
#(
  parameter int unsigned NCAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic fall,
  output logic run,
  output logic sdo,
  output logic cap,
  output logic done
);

  localparam int unsigned N_TOT = CMD_LEN + WORD_W + NCAP;
  localparam int unsigned BC_W  = $clog2(N_TOT + 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(N_TOT - 1);
  localparam logic [BC_W-1:0] BC_DATA = BC_W'(CMD_LEN);

  seq_st_e          st_q, st_d;
  logic [BC_W-1:0]  bc_q, bc_d;
  logic             done_q, done_d;
  logic [CMD_LEN-1:0] cmd_sh;
  logic             last;

  always_comb begin
    last   = (bc_q == BC_LAST);
    st_d   = st_q;
    bc_d   = bc_q;
    done_d = 1'b0;
    if (st_q == SEQ_RUN && fall) begin
      if (last) begin
        st_d   = SEQ_HALT;
        done_d = 1'b1;
      end else begin
        bc_d = bc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_RUN;
      bc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bc_q   <= bc_d;
      done_q <= done_d;
    end
  end

  // The command bit for the current serial cycle; the counter moves on falls.
  always_comb begin
    cmd_sh = CMD_SEQ << bc_q;
    sdo    = (st_q == SEQ_RUN) ? cmd_sh[CMD_LEN-1] : 1'b0;
  end

  assign run  = (st_q == SEQ_RUN);
  assign cap  = run && rise && (bc_q >= BC_DATA);
  assign done = done_q;

  // R7: completion is a single pulse and the clock does not restart
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!run && !done));

endmodule

// File: rtl/mw_cap.sv
module mw_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic sdi,
  output logic bit_o,
  output logic valid_o
);

  logic bit_q, bit_d;
  logic vld_q, vld_d;

  always_comb begin
    vld_d = cap;
    bit_d = cap ? sdi : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
      vld_q <= vld_d;
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = vld_q;

  // R4: a bit strobe never lasts longer than one cycle
  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

endmodule

// File: rtl/mw_cfg_reader.sv
module mw_cfg_reader #(
  parameter int unsigned HALF_DIV = 4,
  parameter bit          WIDE     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output logic sk_o,
  output logic sdo_o,
  input  logic sdi_i,
  output logic cfg_bit_o,
  output logic cfg_valid_o,
  output logic done_o
);

  localparam int unsigned NCAP = WIDE ? 3 : 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic run, rise, fall, cap;

  mw_sk_gen #(.HALF_DIV(HALF_DIV)) u_sk_gen (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .sk    (sk_o),
    .rise  (rise),
    .fall  (fall)
  );

  mw_seq #(.NCAP(NCAP)) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rise  (rise),
    .fall  (fall),
    .run   (run),
    .sdo   (sdo_o),
    .cap   (cap),
    .done  (done_o)
  );

  mw_cap u_cap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cap     (cap),
    .sdi     (sdi_i),
    .bit_o   (cfg_bit_o),
    .valid_o (cfg_valid_o)
  );

  // R4: a bit strobe appears only in the cycle the serial clock has just risen
  a_r4_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_valid_o |-> $rose(sk_o));

  // R5: the command line holds while the serial clock is high
  a_r5_sdo_stable_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sk_o && $past(sk_o)) |-> $stable(sdo_o));

endmodule

// File: tb/mw_cfg_reader_bench.sv
module mw_ee_monitor #(
  parameter int HALF = 2,
  parameter int NCAP = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sk,
  input  logic        di,
  output logic        sdo,
  input  logic        cfg_bit,
  input  logic        cfg_valid,
  input  logic        done,
  input  logic [15:0] w0,
  input  logic [15:0] w1,
  output int          checks,
  output int          fails,
  output int          rises,
  output int          dones
);

  localparam int NTOT = 25 + NCAP;

  // Behavioural EEPROM: records command edges, then streams word 0 and word 1.
  int          k;
  logic [31:0] sh;

  always @(posedge sk or negedge rst_n) begin
    if (!rst_n) begin
      k   <= 0;
      sdo <= 1'b0;
      sh  <= '0;
    end else begin
      if (k == 8) begin
        sdo <= w0[15];
        sh  <= {w0[14:0], w1, 1'b0};
      end else if (k > 8) begin
        sdo <= sh[31];
        sh  <= {sh[30:0], 1'b0};
      end
      k <= k + 1;
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    rises  = 0;
    dones  = 0;
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s (NCAP=%0d) t=%0t got %0d expected %0d", req, NCAP, $time, got, exp);
    end
  endtask

  logic        prev_sk, started, di_at;
  int          lenc;
  logic [31:0] ex;
  logic        rs, fl, expv, expd;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R8 sk in reset", int'(sk), 0);
      chk("R8 valid in reset", int'(cfg_valid), 0);
      chk("R8 done in reset", int'(done), 0);
      rises   = 0;
      dones   = 0;
      prev_sk = 1'b0;
      started = 1'b0;
      lenc    = 0;
      di_at   = 1'b0;
      ex      = {w0, w1};
    end else begin
      rs = sk && !prev_sk;
      fl = !sk && prev_sk;
      if (rs) begin
        rises++;
        if (started) chk("R6 low phase length", lenc, HALF);
        started = 1'b1;
        lenc    = 1;
        di_at   = di;
        if (rises <= 9) chk("R1 command bit", int'(di), (rises <= 2) ? 1 : 0);
        if (rises > NTOT) chk("R7 extra sk edge", rises, NTOT);
      end else if (fl) begin
        chk("R6 high phase length", lenc, HALF);
        lenc = 1;
      end else begin
        lenc++;
      end
      if (sk && !rs) chk("R5 sdo stable while sk high", int'(di), int'(di_at));
      expv = rs && (rises >= 10) && (rises <= NTOT);
      chk("R4 valid strobe timing", int'(cfg_valid), int'(expv));
      if (expv) begin
        if (rises <= 25) chk("R2 word 0 bit", int'(cfg_bit), int'(ex[31]));
        else             chk("R3 word 1 bit", int'(cfg_bit), int'(ex[31]));
        ex = {ex[30:0], 1'b0};
      end
      expd = fl && (rises == NTOT);
      chk("R7 done pulse", int'(done), int'(expd));
      if (done) dones++;
      prev_sk = sk;
    end
  end

endmodule

module mw_cfg_reader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_N = 2;
  localparam int HALF_W = 3;

  logic        clk;
  logic        rst_n;
  logic [15:0] w0, w1;

  logic sk_n, sdo_n, sdi_n, bit_n, vld_n, done_n;
  logic sk_w, sdo_w, sdi_w, bit_w, vld_w, done_w;
  int   ck_n, fl_n, rs_n, dn_n;
  int   ck_w, fl_w, rs_w, dn_w;
  int   n_chk, n_fail;
  bit   finished;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  mw_cfg_reader #(.HALF_DIV(HALF_N), .WIDE(1'b0)) u_mw_cfg_reader (
    .clk(clk), .rst_n(rst_n), .sk_o(sk_n), .sdo_o(sdo_n), .sdi_i(sdi_n),
    .cfg_bit_o(bit_n), .cfg_valid_o(vld_n), .done_o(done_n)
  );

  mw_cfg_reader #(.HALF_DIV(HALF_W), .WIDE(1'b1)) u_mw_cfg_reader_wide (
    .clk(clk), .rst_n(rst_n), .sk_o(sk_w), .sdo_o(sdo_w), .sdi_i(sdi_w),
    .cfg_bit_o(bit_w), .cfg_valid_o(vld_w), .done_o(done_w)
  );

  mw_ee_monitor #(.HALF(HALF_N), .NCAP(2)) u_mon_n (
    .clk(clk), .rst_n(rst_n), .sk(sk_n), .di(sdo_n), .sdo(sdi_n),
    .cfg_bit(bit_n), .cfg_valid(vld_n), .done(done_n), .w0(w0), .w1(w1),
    .checks(ck_n), .fails(fl_n), .rises(rs_n), .dones(dn_n)
  );

  mw_ee_monitor #(.HALF(HALF_W), .NCAP(3)) u_mon_w (
    .clk(clk), .rst_n(rst_n), .sk(sk_w), .di(sdo_w), .sdo(sdi_w),
    .cfg_bit(bit_w), .cfg_valid(vld_w), .done(done_w), .w0(w0), .w1(w1),
    .checks(ck_w), .fails(fl_w), .rises(rs_w), .dones(dn_w)
  );

  task automatic top_chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==",
               n_chk + ck_n + ck_w, n_fail + fl_n + fl_w);
      $finish;
    end
  endtask

  task automatic run_case(input logic [15:0] a, input logic [15:0] b, input bit full);
    @(posedge clk); #1;
    rst_n = 1'b0;
    w0 = a;
    w1 = b;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    if (full) begin
      repeat (260) @(posedge clk);
      #1;
      top_chk("R3 narrow rise count 27", rs_n, 27);
      top_chk("R3 wide rise count 28", rs_w, 28);
      top_chk("R7 narrow single done", dn_n, 1);
      top_chk("R7 wide single done", dn_w, 1);
    end else begin
      repeat (60) @(posedge clk);
    end
  endtask

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    w0       = '0;
    w1       = '0;
    run_case(16'hA5C3, 16'h8000, 1'b1);
    run_case(16'hFFFF, 16'hFFFF, 1'b1);
    run_case(16'h0000, 16'h0000, 1'b1);
    run_case(16'h1234, 16'h6000, 1'b0);   // R8: abandoned mid-read
    run_case(16'h5555, 16'h4000, 1'b1);   // R8: restart after abort
    run_case(16'hAAAA, 16'h2000, 1'b1);   // R3: only D13 set in word 1
    run_case(16'h8001, 16'hDFFF, 1'b1);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired got 1 expected 0");
    summary();
  end

endmodule